// File: doc/BRIEF.md
# Smart card contact sequencer

This block brings the contacts of a contact smart card up and down in a safe order. A host issues commands through a one-cycle write strobe that carries a start bit, a stop bit and a clear bit. The block watches four status inputs: card presence, a supply supervisor alarm, an overcurrent flag on the card supply output and a generic hardware fault. From these it drives enables for the supply pump and for the VCC, I/O, CLK and RST contacts. It also raises a session flag for as long as any part of the card interface is powered. Every delay is counted in cycles of the clock that runs the block, which is an internal oscillator and not the host clock.

Activation starts the pump, lets it settle, and then enables VCC, I/O and CLK in turn. RST is released last. A stop command or any emergency ends the session with an automatic deactivation. This deactivation also runs if the emergency arrives part way through activation. It drops RST first and the pump last, with equal gaps between the steps. The reason for an automatic deactivation is latched for the host. A separate selector picks the pump operating mode from the pump kind, the requested card voltage and the supply range. The selected mode is held steady while a session runs.

Top module: `card_contact_seq`

## Requirements
- R1: After reset every contact enable, `pump_en`, `card_rst`, `session_active` and `cause` are 0, and `pump_mode` is 0.
- R2: When the block is idle, a write with `cmd_start`=1 begins activation only if `card_present`=1 and `supv_alarm`=0. Otherwise the write leaves every output unchanged.
- R3: When a start is accepted at clock edge E, `pump_en` rises at E. `vcc_en` rises at E+SETTLE_CYC, `io_en` at E+SETTLE_CYC+STEP_CYC and `clk_en` at E+SETTLE_CYC+2*STEP_CYC. `card_rst` goes high RST_DLY_CYC edges after `clk_en`.
- R4: A write with `cmd_stop`=1 during activation or a session starts deactivation at edge D. `card_rst` falls at D. `clk_en`, `io_en`, `vcc_en` and `pump_en` then fall at D+STEP_CYC, D+2*STEP_CYC, D+3*STEP_CYC and D+4*STEP_CYC respectively.
- R5: During activation or a session, any of `card_present`=0, `supv_alarm`=1, `ovc_flag`=1 or `hw_fault`=1 starts the same deactivation as R4. It takes priority over any activation step that is due in the same cycle.
- R6: In every cycle of activation or session, `cause` ORs in {`hw_fault`, `ovc_flag`, `supv_alarm`, not `card_present`} as bits 3..0. A write with `cmd_clr`=1 clears `cause`, but a new capture in the same cycle wins over the clear.
- R7: A start write during deactivation is ignored, and the deactivation runs to its end unchanged.
- R8: `session_active` rises with `pump_en` and falls only on the edge where `pump_en` falls. No contact enable or `card_rst` is ever high while it is 0.
- R9: With `pump_inductive`=0, the mode is chosen from the card voltage code (0=5 V, 1=3 V, 2/3=1.8 V) and the supply code (0=below 4 V, 1=4 V to 5.8 V, 2/3=above). A 5 V card on supply 0 gives tripler (2). A 5 V card on supply 1 gives doubler (1). A 3 V card on supply 0 gives doubler (1). Every other combination gives follower (0).
- R10: With `pump_inductive`=1, card voltage code 0 gives regulate-5.5 V (3), code 1 gives regulate-4 V (4), and codes 2/3 give follower (0).
- R11: `pump_mode` follows the R9/R10 selection one edge after its inputs only while the block is idle. From the accepted start until deactivation ends, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start bit of the command write |
| cmd_stop | input | 1 | Stop bit of the command write |
| cmd_clr | input | 1 | Clear-cause bit of the command write |
| card_present | input | 1 | Card detected in the socket |
| supv_alarm | input | 1 | Supply supervisor alarm |
| ovc_flag | input | 1 | Card supply overcurrent flag |
| hw_fault | input | 1 | Generic hardware fault |
| pump_inductive | input | 1 | 1 = inductive pump, 0 = capacitive pump |
| card_volt | input | 2 | Requested card voltage code |
| supply_range | input | 2 | Supply range code |
| pump_en | output | 1 | Supply pump running |
| pump_mode | output | 3 | Selected pump mode |
| vcc_en | output | 1 | Card VCC enabled |
| io_en | output | 1 | I/O released from forced low |
| clk_en | output | 1 | Card clock running |
| card_rst | output | 1 | Card reset line level (1 = released) |
| session_active | output | 1 | Card interface powered |
| cause | output | 4 | Latched deactivation reasons |

## Verification
The bench aborts activation at each of its steps with a different emergency source. A design that finished the pending step before honouring the abort would raise VCC or CLK one edge too many, and the per-cycle model would see it. It sends a start while deactivation is under way. A design that re-entered activation there would keep `session_active` high past the last step. It also writes a clear on the same cycle as a live fault, which catches a design that lets the clear win. Finally it changes the voltage and supply codes in mid-session to catch a mode selector that does not freeze.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_PUMP  = 4'd1,
    ST_VCC   = 4'd2,
    ST_IO    = 4'd3,
    ST_CLK   = 4'd4,
    ST_ON    = 4'd5,
    ST_DCLK  = 4'd6,
    ST_DIO   = 4'd7,
    ST_DVCC  = 4'd8,
    ST_DPUMP = 4'd9
  } seq_state_t;

  typedef enum logic [2:0] {
    PM_FOLLOW = 3'd0,
    PM_DOUBLE = 3'd1,
    PM_TRIPLE = 3'd2,
    PM_REG55  = 3'd3,
    PM_REG40  = 3'd4
  } pump_mode_t;

  localparam logic [1:0] VC_5V0 = 2'd0;
  localparam logic [1:0] VC_3V0 = 2'd1;

  localparam logic [1:0] SR_LOW = 2'd0;
  localparam logic [1:0] SR_MID = 2'd1;

  localparam int CAUSE_W = 4;

endpackage

// File: rtl/ccs_mode_sel.sv
module ccs_mode_sel
  import ccs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       freeze,
  input  logic       pump_inductive,
  input  logic [1:0] card_volt,
  input  logic [1:0] supply_range,
  output logic [2:0] pump_mode
);

  pump_mode_t sel_mode;
  pump_mode_t mode_q;

  // Capacitive pump: the boost ratio depends on both the card voltage and the supply range.
  // Inductive pump: the regulation target depends only on the card voltage.
  always_comb begin
    sel_mode = PM_FOLLOW;
    if (pump_inductive) begin
      if (card_volt == VC_5V0)      sel_mode = PM_REG55;
      else if (card_volt == VC_3V0) sel_mode = PM_REG40;
    end else begin
      if (card_volt == VC_5V0 && supply_range == SR_LOW)      sel_mode = PM_TRIPLE;
      else if (card_volt == VC_5V0 && supply_range == SR_MID) sel_mode = PM_DOUBLE;
      else if (card_volt == VC_3V0 && supply_range == SR_LOW) sel_mode = PM_DOUBLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= PM_FOLLOW;
    else if (!freeze) mode_q <= sel_mode;
  end

  assign pump_mode = mode_q;

  // R11: no mode change while a session runs
  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(pump_mode));

endmodule

// File: rtl/ccs_cause_latch.sv
module ccs_cause_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [N-1:0] src,
  input  logic         clr,
  output logic [N-1:0] cause
);

  logic [N-1:0] q;
  logic [N-1:0] set_v;

  assign set_v = capture ? src : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr ? '0 : q) | set_v;
  end

  assign cause = q;

  // R6: a clear with nothing captured empties the latch
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && set_v == '0) |=> (cause == '0));

  // R6: a captured source is visible on the next cycle
  assert_capture_sticks_R6: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((cause & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/ccs_seq_fsm.sv
module ccs_seq_fsm
  import ccs_pkg::*;
#(
  parameter int SETTLE_CYC  = 64,
  parameter int STEP_CYC    = 4,
  parameter int RST_DLY_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic card_present,
  input  logic supv_alarm,
  input  logic emerg,
  output logic pump_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic active,
  output logic in_session,
  output logic idle
);

  localparam int MAX_A   = (SETTLE_CYC > RST_DLY_CYC) ? SETTLE_CYC : RST_DLY_CYC;
  localparam int MAX_CYC = (MAX_A > STEP_CYC) ? MAX_A : STEP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LD   = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] RSTD_LD   = CNT_W'(RST_DLY_CYC - 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             pump_q, vcc_q, io_q, clk_q, rst_q, act_q;
  logic             abort;
  logic             cnt_done;
  logic             go_ok;

  assign in_session = (st == ST_PUMP) || (st == ST_VCC) || (st == ST_IO) ||
                      (st == ST_CLK)  || (st == ST_ON);
  assign idle     = (st == ST_IDLE);
  assign abort    = emerg || stop_req;
  assign cnt_done = (cnt == '0);
  assign go_ok    = start_req && card_present && !supv_alarm;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      pump_q <= 1'b0;
      vcc_q  <= 1'b0;
      io_q   <= 1'b0;
      clk_q  <= 1'b0;
      rst_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (in_session && abort) begin
      // ordered shutdown begins with reset low, from whichever step is current
      rst_q <= 1'b0;
      cnt   <= STEP_LD;
      st    <= ST_DCLK;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go_ok) begin
            pump_q <= 1'b1;
            act_q  <= 1'b1;
            cnt    <= SETTLE_LD;
            st     <= ST_PUMP;
          end
        end
        ST_PUMP: begin
          if (cnt_done) begin
            vcc_q <= 1'b1;
            cnt   <= STEP_LD;
            st    <= ST_VCC;
          end else cnt <= cnt - 1'b1;
        end
        ST_VCC: begin
          if (cnt_done) begin
            io_q <= 1'b1;
            cnt  <= STEP_LD;
            st   <= ST_IO;
          end else cnt <= cnt - 1'b1;
        end
        ST_IO: begin
          if (cnt_done) begin
            clk_q <= 1'b1;
            cnt   <= RSTD_LD;
            st    <= ST_CLK;
          end else cnt <= cnt - 1'b1;
        end
        ST_CLK: begin
          if (cnt_done) begin
            rst_q <= 1'b1;
            st    <= ST_ON;
          end else cnt <= cnt - 1'b1;
        end
        ST_ON: ;
        ST_DCLK: begin
          if (cnt_done) begin
            clk_q <= 1'b0;
            cnt   <= STEP_LD;
            st    <= ST_DIO;
          end else cnt <= cnt - 1'b1;
        end
        ST_DIO: begin
          if (cnt_done) begin
            io_q <= 1'b0;
            cnt  <= STEP_LD;
            st   <= ST_DVCC;
          end else cnt <= cnt - 1'b1;
        end
        ST_DVCC: begin
          if (cnt_done) begin
            vcc_q <= 1'b0;
            cnt   <= STEP_LD;
            st    <= ST_DPUMP;
          end else cnt <= cnt - 1'b1;
        end
        ST_DPUMP: begin
          if (cnt_done) begin
            pump_q <= 1'b0;
            act_q  <= 1'b0;
            st     <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pump_en  = pump_q;
  assign vcc_en   = vcc_q;
  assign io_en    = io_q;
  assign clk_en   = clk_q;
  assign card_rst = rst_q;
  assign active   = act_q;

  // R3: contact ordering while powering up
  assert_vcc_needs_pump_R3: assert property (@(posedge clk) disable iff (rst)
    vcc_en |-> pump_en);
  assert_io_needs_vcc_R3: assert property (@(posedge clk) disable iff (rst)
    io_en |-> vcc_en);
  // R4: contact ordering while powering down
  assert_clk_needs_io_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);
  assert_rst_needs_clk_R4: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> clk_en);
  // R2: refused start leaves the pump off
  assert_start_refused_R2: assert property (@(posedge clk) disable iff (rst)
    (idle && start_req && (!card_present || supv_alarm)) |=> !pump_en);
  // R5: emergency drops reset on the next edge
  assert_emerg_drops_rst_R5: assert property (@(posedge clk) disable iff (rst)
    (in_session && emerg) |=> (!card_rst && st == ST_DCLK));
  // R7: start during shutdown does not restart
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (!idle && !in_session && start_req) |=> !in_session);
  // R8: nothing powered without a session
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !active |-> !(pump_en || vcc_en || io_en || clk_en || card_rst));

endmodule

// File: rtl/card_contact_seq.sv
module card_contact_seq
  import ccs_pkg::*;
#(
  parameter int SETTLE_CYC  = 64,
  parameter int STEP_CYC    = 4,
  parameter int RST_DLY_CYC = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_clr,
  input  logic       card_present,
  input  logic       supv_alarm,
  input  logic       ovc_flag,
  input  logic       hw_fault,
  input  logic       pump_inductive,
  input  logic [1:0] card_volt,
  input  logic [1:0] supply_range,
  output logic       pump_en,
  output logic [2:0] pump_mode,
  output logic       vcc_en,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       session_active,
  output logic [3:0] cause
);

  logic               emerg;
  logic               in_session;
  logic               idle;
  logic [CAUSE_W-1:0] src;

  assign src   = {hw_fault, ovc_flag, supv_alarm, ~card_present};
  assign emerg = |src;

  ccs_seq_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .STEP_CYC   (STEP_CYC),
    .RST_DLY_CYC(RST_DLY_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (cmd_wr && cmd_start),
    .stop_req    (cmd_wr && cmd_stop),
    .card_present(card_present),
    .supv_alarm  (supv_alarm),
    .emerg       (emerg),
    .pump_en     (pump_en),
    .vcc_en      (vcc_en),
    .io_en       (io_en),
    .clk_en      (clk_en),
    .card_rst    (card_rst),
    .active      (session_active),
    .in_session  (in_session),
    .idle        (idle)
  );

  ccs_mode_sel u_mode (
    .clk           (clk),
    .rst           (rst),
    .freeze        (!idle),
    .pump_inductive(pump_inductive),
    .card_volt     (card_volt),
    .supply_range  (supply_range),
    .pump_mode     (pump_mode)
  );

  ccs_cause_latch #(.N(CAUSE_W)) u_cause (
    .clk    (clk),
    .rst    (rst),
    .capture(in_session),
    .src    (src),
    .clr    (cmd_wr && cmd_clr),
    .cause  (cause)
  );

  // R1: clean state straight after reset
  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pump_en && !vcc_en && !io_en && !clk_en && !card_rst &&
                    !session_active && cause == '0 && pump_mode == '0));

endmodule

// File: tb/card_contact_seq_bench.sv
module card_contact_seq_bench;

  localparam int SETTLE = 8;
  localparam int STEP   = 3;
  localparam int RDLY   = 12;
  localparam int ACT_T  = SETTLE + 2*STEP + RDLY + 3;
  localparam int DEA_T  = 4*STEP + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 0, cmd_start = 0, cmd_stop = 0, cmd_clr = 0;
  logic card_present = 1, supv_alarm = 0, ovc_flag = 0, hw_fault = 0;
  logic pump_inductive = 0;
  logic [1:0] card_volt = 0, supply_range = 0;
  logic pump_en, vcc_en, io_en, clk_en, card_rst, session_active;
  logic [2:0] pump_mode;
  logic [3:0] cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  card_contact_seq #(.SETTLE_CYC(SETTLE), .STEP_CYC(STEP), .RST_DLY_CYC(RDLY)) u_card_contact_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clr(cmd_clr), .card_present(card_present), .supv_alarm(supv_alarm),
    .ovc_flag(ovc_flag), .hw_fault(hw_fault), .pump_inductive(pump_inductive),
    .card_volt(card_volt), .supply_range(supply_range), .pump_en(pump_en),
    .pump_mode(pump_mode), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .session_active(session_active), .cause(cause));

  function automatic int exp_mode(input logic ind, input logic [1:0] v, input logic [1:0] s);
    if (ind) begin
      if (v == 0) return 3;
      if (v == 1) return 4;
      return 0;
    end
    if (v == 0 && s == 0) return 2;
    if (v == 0 && s == 1) return 1;
    if (v == 1 && s == 0) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: phase number plus a countdown of cycles to the next action
  int m_pump, m_vcc, m_io, m_clk, m_rst, m_act, m_mode, m_cause, ph, left;
  always @(posedge clk) begin
    if (rst) begin
      m_pump = 0; m_vcc = 0; m_io = 0; m_clk = 0; m_rst = 0; m_act = 0;
      m_mode = 0; m_cause = 0; ph = 0; left = 0;
    end else begin
      automatic bit emer = !card_present || supv_alarm || ovc_flag || hw_fault;
      automatic bit trig = emer || (cmd_wr && cmd_stop);
      if (ph == 0) m_mode = exp_mode(pump_inductive, card_volt, supply_range);
      if (cmd_wr && cmd_clr) m_cause = 0;
      if (ph >= 1 && ph <= 5)
        m_cause = m_cause | (int'(hw_fault) << 3) | (int'(ovc_flag) << 2) |
                  (int'(supv_alarm) << 1) | int'(!card_present);
      if (ph >= 1 && ph <= 5 && trig) begin
        m_rst = 0; ph = 6; left = STEP;
      end else if (ph == 0) begin
        if (cmd_wr && cmd_start && card_present && !supv_alarm) begin
          m_pump = 1; m_act = 1; ph = 1; left = SETTLE;
        end
      end else if (ph != 5) begin
        left--;
        if (left == 0) begin
          case (ph)
            1: begin m_vcc = 1; ph = 2; left = STEP; end
            2: begin m_io = 1;  ph = 3; left = STEP; end
            3: begin m_clk = 1; ph = 4; left = RDLY; end
            4: begin m_rst = 1; ph = 5; end
            6: begin m_clk = 0; ph = 7; left = STEP; end
            7: begin m_io = 0;  ph = 8; left = STEP; end
            8: begin m_vcc = 0; ph = 9; left = STEP; end
            9: begin m_pump = 0; m_act = 0; ph = 0; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 R4 R5 pump_en", int'(pump_en), m_pump);
      chk("R3 R4 R5 vcc_en",  int'(vcc_en),  m_vcc);
      chk("R3 R4 R5 io_en",   int'(io_en),   m_io);
      chk("R3 R4 R5 clk_en",  int'(clk_en),  m_clk);
      chk("R3 R4 R5 card_rst", int'(card_rst), m_rst);
      chk("R8 session_active", int'(session_active), m_act);
      chk("R6 cause", int'(cause), m_cause);
      chk("R9 R10 R11 pump_mode", int'(pump_mode), m_mode);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmd(input bit s, input bit p, input bit c);
    @(negedge clk);
    cmd_wr = 1; cmd_start = s; cmd_stop = p; cmd_clr = c;
    @(negedge clk);
    cmd_wr = 0; cmd_start = 0; cmd_stop = 0; cmd_clr = 0;
  endtask

  initial begin
    wait_n(3);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 contacts after reset", int'({pump_en, vcc_en, io_en, clk_en, card_rst}), 0);
    chk("R1 session after reset", int'(session_active), 0);
    chk("R1 cause after reset", int'(cause), 0);

    // R2: refused starts
    card_present = 0;
    write_cmd(1, 0, 0);
    wait_n(2);
    chk("R2 start without card", int'(pump_en), 0);
    card_present = 1; supv_alarm = 1;
    write_cmd(1, 0, 0);
    wait_n(2);
    chk("R2 start under supervisor alarm", int'(session_active), 0);
    supv_alarm = 0;

    // R9 R10: mode sweep while idle
    for (int ind = 0; ind < 2; ind++)
      for (int v = 0; v < 4; v++)
        for (int s = 0; s < 4; s++) begin
          @(negedge clk);
          pump_inductive = ind[0]; card_volt = v[1:0]; supply_range = s[1:0];
          @(negedge clk);
          if (ind == 0) chk("R9 capacitive mode", int'(pump_mode), exp_mode(0, v[1:0], s[1:0]));
          else          chk("R10 inductive mode", int'(pump_mode), exp_mode(1, v[1:0], s[1:0]));
        end

    // R3 R11: full activation, mode frozen on later input change
    pump_inductive = 0; card_volt = 0; supply_range = 0;
    write_cmd(1, 0, 0);
    card_volt = 1; supply_range = 1;
    wait_n(ACT_T);
    chk("R3 reset released after activation", int'(card_rst), 1);
    chk("R11 mode held in session", int'(pump_mode), 2);

    // R4 R7: host stop, start attempt during shutdown
    write_cmd(0, 1, 0);
    write_cmd(1, 0, 0);
    wait_n(DEA_T);
    chk("R7 no restart during shutdown", int'(session_active), 0);
    chk("R4 all contacts low after stop", int'({pump_en, vcc_en, io_en, clk_en, card_rst}), 0);
    chk("R6 host stop sets no cause", int'(cause), 0);

    // R5 R6: overcurrent in session
    write_cmd(1, 0, 0);
    wait_n(ACT_T);
    @(negedge clk); ovc_flag = 1;
    @(negedge clk); ovc_flag = 0;
    chk("R5 overcurrent drops reset", int'(card_rst), 0);
    wait_n(DEA_T);
    chk("R6 overcurrent cause", int'(cause), 4);
    write_cmd(0, 0, 1);
    @(negedge clk);
    chk("R6 cause cleared", int'(cause), 0);

    // R5: removal during pump settle
    write_cmd(1, 0, 0);
    wait_n(2);
    card_present = 0;
    @(negedge clk); card_present = 1;
    wait_n(DEA_T);
    chk("R5 removal aborts settle", int'(vcc_en), 0);
    chk("R6 removal cause", int'(cause), 1);

    // R5: supervisor alarm during VCC step, hardware fault during CLK wait
    write_cmd(1, 0, 0);
    wait_n(SETTLE + 1);
    supv_alarm = 1;
    @(negedge clk); supv_alarm = 0;
    wait_n(DEA_T);
    write_cmd(1, 0, 0);
    wait_n(SETTLE + 2*STEP + 3);
    hw_fault = 1;
    // R6: clear in the same cycle as a live capture
    cmd_wr = 1; cmd_clr = 1;
    @(negedge clk); hw_fault = 0; cmd_wr = 0; cmd_clr = 0;
    chk("R6 capture beats clear", int'(cause[3]), 1);
    wait_n(DEA_T);
    chk("R8 session ends after fault", int'(session_active), 0);

    wait_n(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule